// File: doc/BRIEF.md
# Host Word-Transfer Handshake Controller

This block sits between a serial-bus terminal core and a host-side RAM. It moves one 16-bit word at a time across a parallel data highway. When a word is waiting, it raises a request to the host. The host answers with a grant and then an acknowledge. The block then pulses a one-cycle data strobe that a RAM can use directly as its write or read enable. The direction line follows the transmit/receive bit of the command that opened the message. A receive message writes into RAM and a transmit message reads out of it.

For the whole message the block presents two outputs that the host can wire together as a RAM address. One is the command word captured when the message began. The other is a word counter that clears at the start of the message and steps once per completed word. A busy input keeps the block from starting new requests. A buffer-enable input gates the highway drivers. If the host does not grant within a parameterised number of cycles, the block drops the word, returns to idle and pulls an active-low failure flag low. The flag stays low until the next message begins.

The core side is reduced to a message-start pulse carrying the command, a message-end pulse, a received-word valid pulse with its data, and a transmit-word need pulse. The answer to a need pulse is a one-cycle valid strobe with the word read from RAM.

Top module: `host_word_dma`

## Requirements
- R1: One cycle after `msg_start` is sampled, `msg_begin` is high for exactly one cycle. In the same cycle `cmd_latch` shows the sampled `cmd_in`, `word_cnt` is 0, `cmd_active` is high and `hs_fail_n` is high. `cmd_active` stays high until the cycle after `msg_end` is sampled.
- R2: `rd_wr_n` equals bit 10 of `cmd_latch`. A value of 1 means a transmit message that reads from RAM. A value of 0 means a receive message that writes to RAM.
- R3: A `core_rx_valid` or `core_tx_need` pulse sampled while `cmd_active` is high marks a word pending. A pending word raises `xfer_req` two cycles after the pulse, provided `busy` is low.
- R4: `xfer_req` never rises in a cycle that follows a sampled high `busy`. A pending word is kept while `busy` is high, and it is requested once `busy` is low.
- R5: `xfer_req` drops in the cycle after a grant is sampled. `xfer_ack` is then sampled from the next edge onward, and the transfer waits for it.
- R6: `data_stb` is high for exactly one cycle, and that cycle directly follows the edge that samples `xfer_ack`.
- R7: During a receive message, `hwy_dout` carries the captured received word. `hwy_oe` is high only from the cycle after the grant through the strobe cycle, and only while `buf_en` is high. It is always low for transmit messages.
- R8: During a transmit message, the value on `hwy_din` at the end of the strobe cycle appears on `core_tx_data`, with `core_tx_valid` high for exactly the following cycle.
- R9: `word_cnt` increases by one in the cycle after each strobe and wraps modulo 2^CNT_W.
- R10: If no grant arrives, `xfer_req` stays high for exactly GNT_TIMEOUT cycles and then drops. `hs_fail_n` goes low in that same cycle and stays low until the next message start. The abandoned word is not requested again.
- R11: Words offered while `cmd_active` is low are ignored, so no request follows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| msg_start | input | 1 | Pulse marking the start of a message; samples `cmd_in` |
| msg_end | input | 1 | Pulse marking the end of the current message |
| cmd_in | input | DW | Command word that comes with `msg_start` |
| core_rx_valid | input | 1 | Received word ready to be written to RAM |
| core_rx_data | input | DW | Received word |
| core_tx_need | input | 1 | Core asks for the next word to transmit |
| core_tx_valid | output | 1 | One-cycle pulse: `core_tx_data` holds a word read from RAM |
| core_tx_data | output | DW | Word read from RAM |
| busy | input | 1 | Holds off new host requests |
| buf_en | input | 1 | Enables the highway drivers |
| xfer_req | output | 1 | Transfer request to the host |
| xfer_gnt | input | 1 | Host grant |
| xfer_ack | input | 1 | Host acknowledge |
| rd_wr_n | output | 1 | 1 = read from RAM, 0 = write to RAM |
| data_stb | output | 1 | One-cycle RAM data strobe |
| hwy_dout | output | DW | Data driven onto the highway |
| hwy_oe | output | 1 | Highway driver enable |
| hwy_din | input | DW | Data read from the highway |
| word_cnt | output | CNT_W | Word index within the message |
| cmd_latch | output | DW | Command word latched at message start |
| msg_begin | output | 1 | One-cycle message-start marker |
| cmd_active | output | 1 | A command is in progress |
| hs_fail_n | output | 1 | Active-low grant-timeout flag |

## Verification
The bench goes after the grant timeout at its exact edge. If the count is off by one, the request runs one cycle too long or too short, and the failure flag falls a cycle early or late. If the dropped word is left pending, a second request appears with no new word behind it. Busy is held across a pending word and buf_en is removed during a receive transfer. A wrong gate on either shows up as a request during busy, or as the highway driven without permission. A full message of 2^CNT_W+1 words checks that the word counter wraps and that each strobe lasts exactly one cycle. Words offered outside a command must never lead to a request.

// File: rtl/host_word_dma_pkg.sv
package host_word_dma_pkg;

  // Word-transfer phases seen by the host.
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_REQ  = 2'd1,
    XS_ACK  = 2'd2,
    XS_STB  = 2'd3
  } xfer_state_e;

endpackage

// File: rtl/hwd_grant_timer.sv
module hwd_grant_timer #(
  parameter int unsigned LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Last cycle of the waiting window.
  assign expired = run && (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/hwd_msg_ctx.sv
module hwd_msg_ctx #(
  parameter int unsigned DW      = 16,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned DIR_BIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic             msg_end,
  input  logic [DW-1:0]    cmd_in,
  input  logic             word_done,
  input  logic             grant_lost,
  output logic [DW-1:0]    cmd_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_q,
  output logic             begin_q,
  output logic             fail_n_q,
  output logic             tx_dir
);
  logic [DW-1:0]    cmd_d;
  logic [CNT_W-1:0] cnt_d;
  logic             active_d, fail_n_d;

  always_comb begin
    cmd_d    = cmd_q;
    cnt_d    = cnt_q;
    active_d = active_q;
    fail_n_d = fail_n_q;
    if (msg_start) begin
      cmd_d    = cmd_in;
      cnt_d    = '0;
      active_d = 1'b1;
      fail_n_d = 1'b1;
    end else begin
      if (word_done)  cnt_d    = cnt_q + 1'b1;
      if (msg_end)    active_d = 1'b0;
      if (grant_lost) fail_n_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      begin_q  <= 1'b0;
      fail_n_q <= 1'b1;
    end else begin
      cmd_q    <= cmd_d;
      cnt_q    <= cnt_d;
      active_q <= active_d;
      begin_q  <= msg_start;
      fail_n_q <= fail_n_d;
    end
  end

  assign tx_dir = cmd_q[DIR_BIT];

endmodule

// File: rtl/host_word_dma.sv
module host_word_dma
  import host_word_dma_pkg::*;
#(
  parameter int unsigned DW          = 16,
  parameter int unsigned CNT_W       = 5,
  parameter int unsigned DIR_BIT     = 10,
  parameter int unsigned GNT_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic             msg_end,
  input  logic [DW-1:0]    cmd_in,
  input  logic             core_rx_valid,
  input  logic [DW-1:0]    core_rx_data,
  input  logic             core_tx_need,
  output logic             core_tx_valid,
  output logic [DW-1:0]    core_tx_data,
  input  logic             busy,
  input  logic             buf_en,
  output logic             xfer_req,
  input  logic             xfer_gnt,
  input  logic             xfer_ack,
  output logic             rd_wr_n,
  output logic             data_stb,
  output logic [DW-1:0]    hwy_dout,
  output logic             hwy_oe,
  input  logic [DW-1:0]    hwy_din,
  output logic [CNT_W-1:0] word_cnt,
  output logic [DW-1:0]    cmd_latch,
  output logic             msg_begin,
  output logic             cmd_active,
  output logic             hs_fail_n
);
  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  xfer_state_e   state_q, state_d;
  logic          pend_q, pend_d;
  logic [DW-1:0] hold_q;
  logic          tx_valid_q;
  logic [DW-1:0] tx_data_q;
  logic          expired, word_done, grant_lost, take_word, tx_dir;

  hwd_grant_timer #(.LIMIT(GNT_TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (state_q == XS_REQ),
    .expired (expired)
  );

  assign word_done  = (state_q == XS_STB) && !msg_start;
  assign grant_lost = (state_q == XS_REQ) && !xfer_gnt && expired && !msg_start;
  assign take_word  = cmd_active && (core_rx_valid || core_tx_need);

  hwd_msg_ctx #(.DW(DW), .CNT_W(CNT_W), .DIR_BIT(DIR_BIT)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .msg_start  (msg_start),
    .msg_end    (msg_end),
    .cmd_in     (cmd_in),
    .word_done  (word_done),
    .grant_lost (grant_lost),
    .cmd_q      (cmd_latch),
    .cnt_q      (word_cnt),
    .active_q   (cmd_active),
    .begin_q    (msg_begin),
    .fail_n_q   (hs_fail_n),
    .tx_dir     (tx_dir)
  );

  // Next-state logic of the handshake.
  always_comb begin
    state_d = state_q;
    if (msg_start) begin
      state_d = XS_IDLE;
    end else begin
      unique case (state_q)
        XS_IDLE: if (pend_q && cmd_active && !busy) state_d = XS_REQ;
        XS_REQ:  if (xfer_gnt)                      state_d = XS_ACK;
                 else if (expired)                  state_d = XS_IDLE;
        XS_ACK:  if (xfer_ack)                      state_d = XS_STB;
        XS_STB:                                     state_d = XS_IDLE;
        default:                                    state_d = XS_IDLE;
      endcase
    end
  end

  always_comb begin
    if (msg_start)                     pend_d = 1'b0;
    else if (take_word)                pend_d = 1'b1;
    else if (word_done || grant_lost)  pend_d = 1'b0;
    else                               pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q    <= XS_IDLE;
      pend_q     <= 1'b0;
      tx_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pend_q     <= pend_d;
      tx_valid_q <= word_done && tx_dir;
    end
  end

  // Data registers with explicit enables.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_q    <= '0;
      tx_data_q <= '0;
    end else begin
      if (core_rx_valid && cmd_active) hold_q    <= core_rx_data;
      if (word_done && tx_dir)         tx_data_q <= hwy_din;
    end
  end

  assign xfer_req      = (state_q == XS_REQ);
  assign data_stb      = (state_q == XS_STB);
  assign rd_wr_n       = tx_dir;
  assign hwy_dout      = hold_q;
  assign hwy_oe        = buf_en && !tx_dir &&
                         ((state_q == XS_ACK) || (state_q == XS_STB));
  assign core_tx_valid = tx_valid_q;
  assign core_tx_data  = tx_data_q;

endmodule

// File: rtl/host_word_dma_chk.sv
module host_word_dma_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_start,
  input logic             busy,
  input logic             buf_en,
  input logic             xfer_req,
  input logic             xfer_gnt,
  input logic             data_stb,
  input logic             rd_wr_n,
  input logic             hwy_oe,
  input logic [CNT_W-1:0] word_cnt,
  input logic             msg_begin,
  input logic             cmd_active,
  input logic             hs_fail_n,
  input logic             core_tx_valid
);
  p_begin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_begin |-> (word_cnt == '0 && cmd_active && hs_fail_n));

  p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_req) |-> !$past(busy));

  p_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && xfer_gnt && !msg_start) |=> !xfer_req);

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb |=> !data_stb);

  p_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_oe |-> (buf_en && !rd_wr_n));

  p_txv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_tx_valid |-> ($past(data_stb) && rd_wr_n));

  p_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_stb && !msg_start) |=> (word_cnt == $past(word_cnt) + 1'b1));

  p_fail_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_fail_n) |-> ($past(xfer_req) && !xfer_req));

endmodule

bind host_word_dma host_word_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .msg_start     (msg_start),
  .busy          (busy),
  .buf_en        (buf_en),
  .xfer_req      (xfer_req),
  .xfer_gnt      (xfer_gnt),
  .data_stb      (data_stb),
  .rd_wr_n       (rd_wr_n),
  .hwy_oe        (hwy_oe),
  .word_cnt      (word_cnt),
  .msg_begin     (msg_begin),
  .cmd_active    (cmd_active),
  .hs_fail_n     (hs_fail_n),
  .core_tx_valid (core_tx_valid)
);

// File: tb/host_word_dma_test.sv
module host_word_dma_test;
  localparam int DW = 16;
  localparam int CW = 5;
  localparam int TMO = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic msg_start = 0, msg_end = 0, core_rx_valid = 0, core_tx_need = 0;
  logic busy = 0, buf_en = 1, xfer_gnt = 0, xfer_ack = 0;
  logic [DW-1:0] cmd_in = '0, core_rx_data = '0, hwy_din = '0;
  logic core_tx_valid, xfer_req, rd_wr_n, data_stb, hwy_oe;
  logic msg_begin, cmd_active, hs_fail_n;
  logic [DW-1:0] core_tx_data, hwy_dout, cmd_latch;
  logic [CW-1:0] word_cnt;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  host_word_dma uut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_end(msg_end),
    .cmd_in(cmd_in), .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
    .core_tx_need(core_tx_need), .core_tx_valid(core_tx_valid),
    .core_tx_data(core_tx_data), .busy(busy), .buf_en(buf_en),
    .xfer_req(xfer_req), .xfer_gnt(xfer_gnt), .xfer_ack(xfer_ack),
    .rd_wr_n(rd_wr_n), .data_stb(data_stb), .hwy_dout(hwy_dout),
    .hwy_oe(hwy_oe), .hwy_din(hwy_din), .word_cnt(word_cnt),
    .cmd_latch(cmd_latch), .msg_begin(msg_begin), .cmd_active(cmd_active),
    .hs_fail_n(hs_fail_n)
  );

  // Behavioural reference: phase 0 idle, 1 requesting, 2 awaiting ack, 3 strobe.
  int m_st, m_tmr, m_cnt;
  bit m_pend, m_act, m_beg, m_fail, m_txv;
  logic [DW-1:0] m_hold, m_cmd, m_txd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tmr = 0; m_cnt = 0; m_pend = 0; m_act = 0; m_beg = 0;
      m_fail = 0; m_txv = 0; m_hold = '0; m_cmd = '0; m_txd = '0;
    end else begin
      bit old_act;
      old_act = m_act;
      if (msg_start) begin
        m_act = 1; m_cmd = cmd_in; m_cnt = 0; m_beg = 1; m_fail = 0;
        m_st = 0; m_pend = 0; m_txv = 0;
      end else begin
        m_beg = 0; m_txv = 0;
        if (m_st == 0) begin
          if (m_pend && old_act && !busy) begin m_st = 1; m_tmr = 0; end
        end else if (m_st == 1) begin
          if (xfer_gnt) m_st = 2;
          else if (m_tmr == TMO - 1) begin m_st = 0; m_fail = 1; m_pend = 0; end
          else m_tmr = m_tmr + 1;
        end else if (m_st == 2) begin
          if (xfer_ack) m_st = 3;
        end else begin
          m_st = 0; m_cnt = (m_cnt + 1) % (1 << CW); m_pend = 0;
          if (m_cmd[10]) begin m_txv = 1; m_txd = hwy_din; end
        end
        if (msg_end) m_act = 0;
        if (old_act && (core_rx_valid || core_tx_need)) m_pend = 1;
      end
      if (old_act && core_rx_valid) m_hold = core_rx_data;
    end
  end

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from both clock edges.
  always begin
    @(negedge clk);
    #1;
    begin
      bit exp_oe;
      exp_oe = buf_en && !m_cmd[10] && (m_st == 2 || m_st == 3);
      cmp("R3", "xfer_req", xfer_req, (m_st == 1));
      cmp("R6", "data_stb", data_stb, (m_st == 3));
      cmp("R2", "rd_wr_n", rd_wr_n, m_cmd[10]);
      cmp("R7", "hwy_oe", hwy_oe, exp_oe);
      if (exp_oe) cmp("R7", "hwy_dout", hwy_dout, m_hold);
      cmp("R9", "word_cnt", word_cnt, m_cnt);
      cmp("R1", "cmd_latch", cmd_latch, m_cmd);
      cmp("R1", "msg_begin", msg_begin, m_beg);
      cmp("R1", "cmd_active", cmd_active, m_act);
      cmp("R10", "hs_fail_n", hs_fail_n, !m_fail);
      cmp("R8", "core_tx_valid", core_tx_valid, m_txv);
      if (m_txv) cmp("R8", "core_tx_data", core_tx_data, m_txd);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_msg(logic [DW-1:0] c);
    @(negedge clk); msg_start = 1; cmd_in = c;
    @(negedge clk); msg_start = 0;
  endtask

  task automatic end_msg();
    @(negedge clk); msg_end = 1;
    @(negedge clk); msg_end = 0;
  endtask

  task automatic offer(bit rx, logic [DW-1:0] d);
    @(negedge clk);
    if (rx) begin core_rx_valid = 1; core_rx_data = d; end
    else core_tx_need = 1;
    @(negedge clk); core_rx_valid = 0; core_tx_need = 0;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 300; i++) begin
      if (xfer_req) break;
      @(negedge clk);
    end
  endtask

  // One full word with grant and ack delays (R5, R6).
  task automatic word(bit rx, logic [DW-1:0] d, int gd, int ad, logic [DW-1:0] din);
    offer(rx, d);
    wait_req();
    repeat (gd) @(negedge clk);
    xfer_gnt = 1;
    @(negedge clk); xfer_gnt = 0;
    repeat (ad) @(negedge clk);
    xfer_ack = 1; hwy_din = din;
    @(negedge clk); xfer_ack = 0;
    idle(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(4);
    cmp("R1", "reset cmd_active", cmd_active, 0);
    cmp("R10", "reset hs_fail_n", hs_fail_n, 1);

    // R11: no command yet, offered word must not be requested.
    offer(1, 16'h1111);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1; cmp("R11", "req while inactive", xfer_req, 0);
    end

    // Receive message with assorted delays.
    start_msg(16'h0821);
    word(1, 16'hA5A5, 0, 0, '0);
    word(1, 16'h5A5A, 3, 2, '0);
    word(1, 16'h0F0F, 7, 5, '0);
    // R7: drivers disabled by buf_en
    buf_en = 0;
    word(1, 16'hC3C3, 1, 2, '0);
    buf_en = 1;
    // R4: busy holds the pending word
    busy = 1;
    offer(1, 16'h7777);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1; cmp("R4", "req during busy", xfer_req, 0);
    end
    busy = 0;
    wait_req();
    #1; cmp("R4", "req after busy", xfer_req, 1);
    @(negedge clk); xfer_gnt = 1;
    @(negedge clk); xfer_gnt = 0; xfer_ack = 1;
    @(negedge clk); xfer_ack = 0;
    idle(2);
    end_msg();

    // Transmit message (bit 10 set) - R8.
    start_msg(16'h0C42);
    word(0, '0, 2, 1, 16'hBEEF);
    word(0, '0, 0, 3, 16'h1234);
    end_msg();

    // R10: grant timeout, then cleared by next message.
    start_msg(16'h0403);
    offer(1, 16'h4242);
    idle(TMO + 10);
    #1;
    cmp("R10", "hs_fail_n after timeout", hs_fail_n, 0);
    cmp("R10", "req after timeout", xfer_req, 0);
    idle(5);
    start_msg(16'h0000);
    idle(1); #1;
    cmp("R10", "fail cleared on start", hs_fail_n, 1);

    // R9: wrap of the word counter.
    for (int k = 0; k < (1 << CW) + 1; k++) word(1, DW'(k * 3 + 1), 0, 0, '0);
    #1; cmp("R9", "count after wrap", word_cnt, 1);
    end_msg();
    idle(5);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule